// File: doc/BRIEF.md
# Interrupt-Driven Descriptor Transfer Engine

This block moves one data item between a peripheral register and a memory buffer each time an enabled interrupt request arrives, so that no CPU handler has to run for that item. It holds no per-channel state of its own. Every service reads an 8-byte channel descriptor from a fixed RAM window, performs one read and one write through a single-port memory master, and writes the updated descriptor back. The CPU is held by a stall output for as long as a service is running.

Each interrupt source has a small control register. It holds an enable bit, a 4-bit channel number selecting one of 16 descriptors, and a 2-bit end code. When the transfer count reaches zero, or the peripheral signals stop during a transfer, the engine records the end code and clears the enable bit. It does not acknowledge the request, so the still-asserted request comes out as an ordinary CPU interrupt and the handler can read the end code. If several enabled requests are pending at the same time, they are served one after another, starting with the highest source number.

Top module: `irq_xfer_engine`

## Requirements
- R1: A request on a source whose enable bit is set, seen while the engine is idle, raises `cpu_stall` on the next clock edge. `cpu_stall` then stays high for exactly 10 cycles. Memory is accessed only while `cpu_stall` is high.
- R2: The descriptor of channel c sits at byte address 0x0100 + 8*c, in little-endian 16-bit words. Byte +0 is the mode, +2 the count, +4 the I/O address and +6 the buffer address. Mode bit 0 is direction, bit 1 is width, bit 2 is buffer increment and bit 3 is I/O increment. All descriptor accesses stay inside 0x0100..0x017F.
- R3: With mode bit 0 = 0 the item is copied from the I/O address to the buffer address. With mode bit 0 = 1 it is copied from the buffer address to the I/O address.
- R4: With mode bit 1 = 1 a 16-bit word (two bytes) is moved. With mode bit 1 = 0 only one byte is written, and the byte above the destination is left unchanged.
- R5: The buffer address written back is the old value plus the item size (1 or 2) when mode bit 2 = 1, and is unchanged otherwise.
- R6: The I/O address written back is the old value plus the item size (1 or 2) when mode bit 3 = 1, and is unchanged otherwise.
- R7: The count written back is the old count minus one. When it reaches zero, the source's end code becomes 01, its enable bit clears, no acknowledge is given, and `cpu_irq` for that source goes high.
- R8: If `stop_req` of the source is high when the item moves, the end code becomes 11 and the enable bit clears, even if the count also reached zero. The transfer and the write-back still happen.
- R9: A service that does not end pulses `svc_ack` for that source for one cycle, the last stall cycle. The end code stays 00 and the enable bit stays set. The peripheral must drop its request within that cycle.
- R10: A request on a source whose enable bit is clear appears on `cpu_irq` in the same cycle. It causes no stall and no memory access.
- R11: When several enabled requests are pending, the highest source number is served first. The others follow, one service at a time.
- R12: A control write (`cfg_we`) loads the enable bit and the channel number of `cfg_src` and sets its end code to 00.
- R13: After reset all enable bits and end codes are 0, and `cpu_stall`, `mem_req` and `svc_ack` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | NSRC | Level interrupt requests from peripherals |
| stop_req | input | NSRC | Per-source stop indication sampled when the item moves |
| cfg_we | input | 1 | Control register write strobe |
| cfg_src | input | SRC_W | Source whose control register is written |
| cfg_en | input | 1 | Enable value to write |
| cfg_ch | input | CH_W | Channel number to write |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_wide | output | 1 | 16-bit access (1) or byte access (0) |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | DW | Write data, low byte at mem_addr |
| mem_rdata | input | DW | Read data, valid one cycle after a read request |
| cpu_stall | output | 1 | Holds the CPU during a service |
| cpu_irq | output | NSRC | Ordinary interrupt to the CPU |
| svc_ack | output | NSRC | One-cycle acknowledge for a service that did not end |
| icr_en | output | NSRC | Enable bit of each source |
| icr_status | output | 2*NSRC | End code of each source, two bits per source |

## Verification
A request driven at a falling edge is taken at the next rising edge, and `cpu_stall` is high from that edge for ten cycles. The bench counts the high cycles at falling edges and checks the count against ten. It samples memory, end codes, enable bits and `cpu_irq` at the first falling edge where `cpu_stall` is low again, because the last descriptor write and the end-code update land on the edge just before it. `svc_ack` exists only in the final stall cycle, so a monitor latches it at falling edges. `cpu_irq` for a disabled source is combinational and is checked just after the request is driven. Priority is checked at the gap between two services by looking at which descriptor has been written back.

// File: rtl/dte_pkg.sv
package dte_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_RD0, ST_RD1, ST_RD2, ST_RD3,
        ST_XR, ST_XW, ST_WB0, ST_WB1, ST_WB2, ST_FIN
    } state_e;

    localparam int MB_DIR  = 0;
    localparam int MB_WIDE = 1;
    localparam int MB_BINC = 2;
    localparam int MB_IINC = 3;

    localparam logic [1:0] END_ACTIVE = 2'b00;
    localparam logic [1:0] END_COUNT  = 2'b01;
    localparam logic [1:0] END_STOP   = 2'b11;
endpackage

// File: rtl/dte_arb.sv
module dte_arb #(
    parameter int NSRC  = 8,
    parameter int SRC_W = $clog2(NSRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  pend,
    output logic             grant_vld,
    output logic [SRC_W-1:0] grant_src
);
    always_comb begin
        grant_vld = 1'b0;
        grant_src = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (pend[i]) begin
                grant_vld = 1'b1;
                grant_src = SRC_W'(i);
            end
        end
    end

    // R11: granted source is pending and nothing above it is
    a_r11_highest_first: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld |-> ((pend >> grant_src) == NSRC'(1)));
endmodule

// File: rtl/dte_icr.sv
module dte_icr import dte_pkg::*; #(
    parameter int NSRC  = 8,
    parameter int SRC_W = $clog2(NSRC),
    parameter int CH_W  = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [SRC_W-1:0]       cfg_src,
    input  logic                   cfg_en,
    input  logic [CH_W-1:0]        cfg_ch,
    input  logic                   start_we,
    input  logic [SRC_W-1:0]       start_src,
    input  logic                   done_we,
    input  logic [SRC_W-1:0]       done_src,
    input  logic [1:0]             done_code,
    output logic [NSRC-1:0]        en,
    output logic [NSRC*CH_W-1:0]   ch_flat,
    output logic [2*NSRC-1:0]      st_flat
);
    typedef struct packed {
        logic [NSRC-1:0]           en;
        logic [NSRC-1:0][CH_W-1:0] ch;
        logic [NSRC-1:0][1:0]      st;
    } icr_t;

    icr_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (start_we) r_d.st[start_src] = END_ACTIVE;
        if (cfg_we) begin
            r_d.en[cfg_src] = cfg_en;
            r_d.ch[cfg_src] = cfg_ch;
            r_d.st[cfg_src] = END_ACTIVE;
        end
        if (done_we) begin
            r_d.en[done_src] = 1'b0;
            r_d.st[done_src] = done_code;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign en      = r_q.en;
    assign ch_flat = r_q.ch;
    assign st_flat = r_q.st;

    // R7 / R8: an end code is recorded and the source disabled
    a_r7_end_recorded: assert property (@(posedge clk) disable iff (!rst_n)
        done_we |=> (!r_q.en[$past(done_src)] && r_q.st[$past(done_src)] == $past(done_code)));

    // R12: a control write leaves the end code at 00
    a_r12_cfg_clears_code: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !(done_we && done_src == cfg_src)) |=> (r_q.st[$past(cfg_src)] == END_ACTIVE));
endmodule

// File: rtl/dte_engine.sv
module dte_engine import dte_pkg::*; #(
    parameter int NSRC      = 8,
    parameter int SRC_W     = $clog2(NSRC),
    parameter int NCH       = 16,
    parameter int CH_W      = $clog2(NCH),
    parameter int AW        = 16,
    parameter int DW        = 16,
    parameter int DESC_BASE = 'h100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             grant_vld,
    input  logic [SRC_W-1:0] grant_src,
    input  logic [CH_W-1:0]  grant_ch,
    input  logic [NSRC-1:0]  stop_req,
    input  logic [DW-1:0]    mem_rdata,
    output logic             mem_req,
    output logic             mem_we,
    output logic             mem_wide,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    output logic             cpu_stall,
    output logic             start_we,
    output logic             done_we,
    output logic [SRC_W-1:0] done_src,
    output logic [1:0]       done_code,
    output logic [NSRC-1:0]  svc_ack
);
    localparam int DESC_BYTES = 8;
    localparam int DESC_SHIFT = $clog2(DESC_BYTES);
    localparam int WIN_LO     = DESC_BASE;
    localparam int WIN_HI     = DESC_BASE + NCH * DESC_BYTES;

    typedef struct packed {
        state_e           st;
        logic [SRC_W-1:0] src;
        logic [AW-1:0]    base;
        logic [7:0]       mode;
        logic [DW-1:0]    cnt;
        logic [AW-1:0]    io;
        logic [AW-1:0]    bf;
        logic             stop;
    } eng_t;

    eng_t r_d, r_q;
    logic [AW-1:0] step;
    logic          desc_phase;

    assign step = r_q.mode[MB_WIDE] ? AW'(2) : AW'(1);

    always_comb begin
        r_d       = r_q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_wide  = 1'b1;
        mem_addr  = '0;
        mem_wdata = '0;
        start_we  = 1'b0;
        done_we   = 1'b0;
        done_code = END_ACTIVE;
        svc_ack   = '0;
        unique case (r_q.st)
            ST_IDLE: if (grant_vld) begin
                r_d.src  = grant_src;
                r_d.base = AW'(DESC_BASE) + (AW'(grant_ch) << DESC_SHIFT);
                start_we = 1'b1;
                r_d.st   = ST_RD0;
            end
            ST_RD0: begin
                mem_req  = 1'b1;
                mem_addr = r_q.base;
                r_d.st   = ST_RD1;
            end
            ST_RD1: begin
                mem_req  = 1'b1;
                mem_addr = r_q.base + AW'(2);
                r_d.mode = mem_rdata[7:0];
                r_d.st   = ST_RD2;
            end
            ST_RD2: begin
                mem_req  = 1'b1;
                mem_addr = r_q.base + AW'(4);
                r_d.cnt  = mem_rdata;
                r_d.st   = ST_RD3;
            end
            ST_RD3: begin
                mem_req  = 1'b1;
                mem_addr = r_q.base + AW'(6);
                r_d.io   = AW'(mem_rdata);
                r_d.st   = ST_XR;
            end
            ST_XR: begin
                r_d.bf   = AW'(mem_rdata);
                mem_req  = 1'b1;
                mem_wide = r_q.mode[MB_WIDE];
                mem_addr = r_q.mode[MB_DIR] ? AW'(mem_rdata) : r_q.io;
                r_d.st   = ST_XW;
            end
            ST_XW: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wide  = r_q.mode[MB_WIDE];
                mem_addr  = r_q.mode[MB_DIR] ? r_q.io : r_q.bf;
                mem_wdata = mem_rdata;
                r_d.stop  = stop_req[r_q.src];
                r_d.cnt   = r_q.cnt - DW'(1);
                if (r_q.mode[MB_BINC]) r_d.bf = r_q.bf + step;
                if (r_q.mode[MB_IINC]) r_d.io = r_q.io + step;
                r_d.st    = ST_WB0;
            end
            ST_WB0: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = r_q.base + AW'(2);
                mem_wdata = r_q.cnt;
                r_d.st    = ST_WB1;
            end
            ST_WB1: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = r_q.base + AW'(4);
                mem_wdata = DW'(r_q.io);
                r_d.st    = ST_WB2;
            end
            ST_WB2: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = r_q.base + AW'(6);
                mem_wdata = DW'(r_q.bf);
                r_d.st    = ST_FIN;
            end
            ST_FIN: begin
                if (r_q.stop) begin
                    done_we   = 1'b1;
                    done_code = END_STOP;
                end else if (r_q.cnt == '0) begin
                    done_we   = 1'b1;
                    done_code = END_COUNT;
                end else begin
                    svc_ack = NSRC'(1) << r_q.src;
                end
                r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign cpu_stall  = (r_q.st != ST_IDLE);
    assign done_src   = r_q.src;
    assign desc_phase = (r_q.st inside {ST_RD0, ST_RD1, ST_RD2, ST_RD3, ST_WB0, ST_WB1, ST_WB2});

    // R1: memory is touched only while the CPU is held
    a_r1_mem_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> cpu_stall);

    // R2: descriptor traffic stays in the descriptor window
    a_r2_desc_window: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_phase && mem_req) |-> (int'(mem_addr) >= WIN_LO && int'(mem_addr) < WIN_HI));

    // R9: at most one source acknowledged at a time
    a_r9_ack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(svc_ack));

    // R7: an ending service is never acknowledged
    a_r7_end_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        done_we |-> (svc_ack == '0));
endmodule

// File: rtl/irq_xfer_engine.sv
module irq_xfer_engine #(
    parameter int NSRC      = 8,
    parameter int SRC_W     = $clog2(NSRC),
    parameter int NCH       = 16,
    parameter int CH_W      = $clog2(NCH),
    parameter int AW        = 16,
    parameter int DW        = 16,
    parameter int DESC_BASE = 'h100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   irq_req,
    input  logic [NSRC-1:0]   stop_req,
    input  logic              cfg_we,
    input  logic [SRC_W-1:0]  cfg_src,
    input  logic              cfg_en,
    input  logic [CH_W-1:0]   cfg_ch,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_wide,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic [DW-1:0]     mem_rdata,
    output logic              cpu_stall,
    output logic [NSRC-1:0]   cpu_irq,
    output logic [NSRC-1:0]   svc_ack,
    output logic [NSRC-1:0]   icr_en,
    output logic [2*NSRC-1:0] icr_status
);
    logic [NSRC*CH_W-1:0] ch_flat;
    logic                 grant_vld;
    logic [SRC_W-1:0]     grant_src;
    logic [CH_W-1:0]      grant_ch;
    logic                 start_we;
    logic                 done_we;
    logic [SRC_W-1:0]     done_src;
    logic [1:0]           done_code;

    assign cpu_irq  = irq_req & ~icr_en;
    assign grant_ch = ch_flat[grant_src*CH_W +: CH_W];

    dte_arb #(.NSRC(NSRC), .SRC_W(SRC_W)) u_arb (
        .clk(clk), .rst_n(rst_n), .pend(irq_req & icr_en),
        .grant_vld(grant_vld), .grant_src(grant_src)
    );

    dte_icr #(.NSRC(NSRC), .SRC_W(SRC_W), .CH_W(CH_W)) u_icr (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_src(cfg_src), .cfg_en(cfg_en), .cfg_ch(cfg_ch),
        .start_we(start_we), .start_src(grant_src),
        .done_we(done_we), .done_src(done_src), .done_code(done_code),
        .en(icr_en), .ch_flat(ch_flat), .st_flat(icr_status)
    );

    dte_engine #(
        .NSRC(NSRC), .SRC_W(SRC_W), .NCH(NCH), .CH_W(CH_W),
        .AW(AW), .DW(DW), .DESC_BASE(DESC_BASE)
    ) u_eng (
        .clk(clk), .rst_n(rst_n),
        .grant_vld(grant_vld), .grant_src(grant_src), .grant_ch(grant_ch),
        .stop_req(stop_req), .mem_rdata(mem_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_wide(mem_wide),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .cpu_stall(cpu_stall),
        .start_we(start_we), .done_we(done_we), .done_src(done_src),
        .done_code(done_code), .svc_ack(svc_ack)
    );

    // R10: a service only starts from an enabled pending request
    a_r10_start_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_stall) |-> $past(|(irq_req & icr_en)));
endmodule

// File: tb/irq_xfer_engine_tb.sv
`timescale 1ns/1ps
module irq_xfer_engine_tb;
    localparam int NSRC = 8;
    localparam int NV   = 6;
    // {src, ch, mode, count, io, buf, stop}, one hex digit per small field
    localparam logic [63:0] VECS [NV] = '{
        64'h2_3_4_0003_0040_0200_0,
        64'h5_0_B_0001_0050_0300_0,
        64'h7_F_2_0004_0060_0400_1,
        64'h0_7_F_0002_0070_0500_0,
        64'h3_9_1_0001_0078_0580_1,
        64'h6_1_6_000A_0080_0600_0
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NSRC-1:0]   irq_req = '0;
    logic [NSRC-1:0]   stop_req = '0;
    logic              cfg_we = 1'b0;
    logic [2:0]        cfg_src = '0;
    logic              cfg_en = 1'b0;
    logic [3:0]        cfg_ch = '0;
    logic              mem_req, mem_we, mem_wide, cpu_stall;
    logic [15:0]       mem_addr, mem_wdata;
    logic [15:0]       mem_rdata = '0;
    logic [NSRC-1:0]   cpu_irq, svc_ack, icr_en;
    logic [2*NSRC-1:0] icr_status;
    logic [NSRC-1:0]   ack_seen = '0;
    logic [7:0]        mem [65536];
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    irq_xfer_engine u_dut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .stop_req(stop_req),
        .cfg_we(cfg_we), .cfg_src(cfg_src), .cfg_en(cfg_en), .cfg_ch(cfg_ch),
        .mem_req(mem_req), .mem_we(mem_we), .mem_wide(mem_wide),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .cpu_stall(cpu_stall), .cpu_irq(cpu_irq), .svc_ack(svc_ack),
        .icr_en(icr_en), .icr_status(icr_status)
    );

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                mem[mem_addr] <= mem_wdata[7:0];
                if (mem_wide) mem[mem_addr + 16'd1] <= mem_wdata[15:8];
            end else begin
                mem_rdata <= {mem_wide ? mem[mem_addr + 16'd1] : 8'h00, mem[mem_addr]};
            end
        end
    end

    // peripheral model: drop the request when acknowledged
    always @(negedge clk) begin
        if (|svc_ack) begin
            irq_req  <= irq_req & ~svc_ack;
            ack_seen <= ack_seen | svc_ack;
        end
    end

    task automatic chk(input string rq, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic logic [15:0] rd16(input logic [15:0] a);
        return {mem[a + 16'd1], mem[a]};
    endfunction

    task automatic wr16(input logic [15:0] a, input logic [15:0] v);
        mem[a] = v[7:0];
        mem[a + 16'd1] = v[15:8];
    endtask

    task automatic cfg(input int s, input bit e, input int c);
        cfg_we = 1'b1; cfg_src = 3'(s); cfg_en = e; cfg_ch = 4'(c);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // counts stall-high cycles until the first falling edge with stall low again
    task automatic wait_service(output int cyc);
        int guard = 0;
        cyc = 0;
        forever begin
            @(negedge clk);
            guard++;
            if (cpu_stall) cyc++;
            else if (cyc > 0) break;
            if (guard > 200) begin
                chk("R1 timeout", cyc, 10);
                break;
            end
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 65536; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R13: reset state
        chk("R13 stall", int'(cpu_stall), 0);
        chk("R13 mem_req", int'(mem_req), 0);
        chk("R13 status", int'(icr_status), 0);
        chk("R13 enable", int'(icr_en), 0);
        chk("R13 ack", int'(svc_ack), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < NV; k++) begin
            logic [63:0] v;
            int s, c, m, cnt, io, bf, stp, sa, da, step, code, cyc;
            logic [15:0] base;
            v = VECS[k];
            s = int'(v[63:60]); c = int'(v[59:56]); m = int'(v[55:52]);
            cnt = int'(v[51:36]); io = int'(v[35:20]); bf = int'(v[19:4]); stp = int'(v[0]);
            base = 16'h0100 + 16'(c * 8);
            sa = m[0] ? bf : io;
            da = m[0] ? io : bf;
            step = m[1] ? 2 : 1;
            wr16(base, 16'(m)); wr16(base + 16'd2, 16'(cnt));
            wr16(base + 16'd4, 16'(io)); wr16(base + 16'd6, 16'(bf));
            mem[16'(sa)] = 8'hA0 + 8'(k); mem[16'(sa + 1)] = 8'hB0 + 8'(k);
            mem[16'(da)] = 8'h00; mem[16'(da + 1)] = 8'hEE;
            cfg(s, 1'b1, c);
            ack_seen = '0;
            stop_req[s] = stp[0];
            irq_req[s] = 1'b1;
            wait_service(cyc);
            code = stp ? 3 : ((cnt - 1) == 0 ? 1 : 0);
            chk("R1 stall cycles", cyc, 10);
            chk("R3 dest low byte", int'(mem[16'(da)]), int'(8'hA0 + 8'(k)));
            chk("R4 dest high byte", int'(mem[16'(da + 1)]), m[1] ? int'(8'hB0 + 8'(k)) : 'hEE);
            chk("R7 count writeback", int'(rd16(base + 16'd2)), (cnt - 1) & 'hFFFF);
            chk("R6 io writeback", int'(rd16(base + 16'd4)), m[3] ? io + step : io);
            chk("R5 buf writeback", int'(rd16(base + 16'd6)), m[2] ? bf + step : bf);
            chk(code == 3 ? "R8 end code" : (code == 1 ? "R7 end code" : "R9 end code"),
                int'(icr_status[2*s +: 2]), code);
            chk("R7 cpu_irq", int'(cpu_irq[s]), code != 0 ? 1 : 0);
            chk("R9 ack", int'(ack_seen[s]), code == 0 ? 1 : 0);
            chk("R8 enable", int'(icr_en[s]), code == 0 ? 1 : 0);
            irq_req[s] = 1'b0;
            stop_req[s] = 1'b0;
            if (k == 1) begin
                cfg(s, 1'b1, c);
                // R12: reconfiguring clears the end code and re-enables
                chk("R12 code cleared", int'(icr_status[2*s +: 2]), 0);
                chk("R12 enable set", int'(icr_en[s]), 1);
                cfg(s, 1'b0, c);
            end
            @(negedge clk);
        end

        // R10: disabled source goes straight to the CPU
        cfg(4, 1'b0, 2);
        irq_req[4] = 1'b1;
        #1;
        chk("R10 cpu_irq", int'(cpu_irq[4]), 1);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R10 no stall", int'(cpu_stall), 0);
            chk("R10 no mem", int'(mem_req), 0);
        end
        irq_req[4] = 1'b0;

        // R11: two simultaneous requests, higher source first
        begin
            int cyc;
            wr16(16'h0150, 16'h0000); wr16(16'h0152, 16'd5); wr16(16'h0154, 16'h0090); wr16(16'h0156, 16'h0700);
            wr16(16'h0158, 16'h0000); wr16(16'h015A, 16'd5); wr16(16'h015C, 16'h0092); wr16(16'h015E, 16'h0702);
            cfg(1, 1'b1, 10);
            cfg(6, 1'b1, 11);
            irq_req[1] = 1'b1;
            irq_req[6] = 1'b1;
            wait_service(cyc);
            chk("R11 higher served first", int'(rd16(16'h015A)), 4);
            chk("R11 lower still waiting", int'(rd16(16'h0152)), 5);
            wait_service(cyc);
            chk("R11 lower served next", int'(rd16(16'h0152)), 4);
            chk("R11 requests acked", int'(irq_req[1] | irq_req[6]), 0);
        end

        repeat (3) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule